// File: doc/BRIEF.md
# Credit-Reserving Read-Return Buffer

This block sits between a flash controller's system-bus master and its core logic. It buffers the data returned by bus read bursts. The bus side issues read requests, and the buffer grants one only after setting aside room for every word that request could bring back. Returned data can then always be written, and the bus never has to stall it.

Returned beats are written on the bus clock. The controller core drains 32-bit words on its own clock, which is asynchronous to the bus clock. The two domains exchange pointers in Gray code through two-flop synchronizers. The read port is first-word-fall-through: the oldest stored word is always on the output while the buffer is not empty. Each domain has its own active-low reset, applied at its own clock edge.

A reservation counter tracks granted words that the core has not yet popped. Each grant adds its burst length to the counter. Pops subtract from it once they have crossed into the bus domain.

Top module: `readret_buffer`

## Requirements
- R1: After both resets, the status outputs are as follows: `rd_empty` is 1, `wr_full` is 0, `wr_overflow` is 0 and `req_outstanding` is 0. All 128 words can be reserved.
- R2: `req_grant` is high in the same cycle as `req_valid` only if `req_len` is between 1 and 16. A request of length 0 or above 16 is refused and leaves the count and the reservation unchanged.
- R3: A request is refused while 8 requests are outstanding.
- R4: A request is refused if `req_len` is greater than 128 minus the reserved words. Reserved words are words granted but not yet popped and seen in the write domain. A request that exactly fills the remaining space is granted.
- R5: `req_outstanding` rises by one on each grant. It falls by one on each write cycle with `wr_last` high, taking effect at the next write-clock edge.
- R6: Words leave the read port in the order they were written. `rd_data` shows the oldest word whenever `rd_empty` is 0, and `rd_en` removes it.
- R7: `wr_full` is 1 while 128 words are stored. A write while full is dropped and sets `wr_overflow`, which stays at 1 until write reset.
- R8: `rd_empty` is 1 when no word is readable. `rd_en` while empty does not move the read pointer.
- R9: Popped words release their reservation. Once the pops reach the write domain, their space can be granted again.
- R10: Each cross-domain pointer is Gray coded, and from one clock edge to the next it changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Bus-side clock |
| wrst_n | input | 1 | Bus-side reset, active low, synchronous |
| req_valid | input | 1 | Read request presented |
| req_len | input | 5 | Burst length of the request in words |
| req_grant | output | 1 | Request accepted this cycle |
| req_outstanding | output | 4 | Granted requests whose last beat is not yet written |
| wr_en | input | 1 | Write one returned beat |
| wr_data | input | 32 | Returned beat |
| wr_last | input | 1 | Beat closes its burst |
| wr_full | output | 1 | 128 words stored |
| wr_overflow | output | 1 | Sticky flag for a write attempted while full |
| rclk | input | 1 | Core-side clock |
| rrst_n | input | 1 | Core-side reset, active low, synchronous |
| rd_en | input | 1 | Pop the word shown on rd_data |
| rd_data | output | 32 | Oldest stored word |
| rd_empty | output | 1 | No readable word |

## Verification
`req_grant` is combinational, so the bench samples it 1 ns after driving the request, before the write-clock edge. `req_outstanding`, `wr_full` and `wr_overflow` change at the next write-clock edge, so they are sampled 1 ns after that edge. Written data reaches `rd_empty` and `rd_data` only after one write-clock register and two read-clock synchronizer flops. Pops reach `wr_full` after two write-clock flops and reach the reservation one flop later. The bench therefore waits at least six cycles of the receiving clock before checking any cross-domain result. Read-side values are sampled at the falling edge of the read clock.

// File: rtl/rrf_pkg.sv
// Package: shared Gray-code helpers and default sizing for the read-return buffer.
// Assumes pointer widths of at most 32 bits.
package rrf_pkg;

    localparam int DEF_DATA_W    = 32;
    localparam int DEF_DEPTH     = 128;
    localparam int DEF_MAX_BURST = 16;
    localparam int DEF_MAX_OUT   = 8;

    // Convert a binary count to its Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Convert a Gray code back to binary by folding all higher bits in.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int i = 1; i < 32; i++) begin
            b = b ^ (g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/rrf_gray_sync.sv
// Module: two-flop synchronizer for a Gray-coded pointer.
// Assumes the source changes by at most one bit per source-clock edge.
module rrf_gray_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture of the foreign pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    assign gray_out = sync_q;

endmodule

// File: rtl/rrf_mem.sv
// Module: storage array, written on the bus clock and read combinationally.
// Assumes a read address is only used after its word's write pointer has crossed over.
module rrf_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    // Capture an accepted beat.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/rrf_wr_ctrl.sv
// Module: bus-side control covering request admission, reservation accounting,
// outstanding-request counting, the write pointer and the full/overflow flags.
// Assumes rgray_s is the read pointer already synchronized into this domain.
module rrf_wr_ctrl
    import rrf_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int MAX_BURST = 16,
    parameter int MAX_OUT   = 8,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1,
    localparam int LEN_W    = $clog2(MAX_BURST + 1),
    localparam int OC_W     = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_grant,
    output logic [OC_W-1:0]  outstanding,
    input  logic             wr_en,
    input  logic             wr_last,
    input  logic [PW-1:0]    rgray_s,
    output logic [PW-1:0]    wbin,
    output logic [PW-1:0]    wgray,
    output logic             mem_we,
    output logic             full,
    output logic             overflow
);
    logic [PW-1:0]   wbin_q, wgray_q, rbin_s, rbin_s_q, occ, popped;
    logic [PW:0]     resv_q, headroom, sum;
    logic [OC_W-1:0] out_q;
    logic            len_ok, slot_ok, space_ok, ovf_q, close_burst;

    assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
    assign occ      = wbin_q - rbin_s;
    assign full     = (occ == PW'(DEPTH));
    assign mem_we   = wr_en && !full;

    // Admission: legal length, a free request slot and enough unreserved space.
    assign headroom = (PW+1)'(DEPTH) - resv_q;
    assign len_ok   = (req_len != '0) && (req_len <= LEN_W'(MAX_BURST));
    assign slot_ok  = (out_q < OC_W'(MAX_OUT));
    assign space_ok = ((PW+1)'(req_len) <= headroom);
    assign req_grant = req_valid && len_ok && slot_ok && space_ok;

    assign popped      = rbin_s - rbin_s_q;
    assign sum         = resv_q + (req_grant ? (PW+1)'(req_len) : '0);
    assign close_burst = wr_en && wr_last && (out_q != '0);

    // Write pointer in binary and Gray form, advanced on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (mem_we) begin
            wbin_q  <= wbin_q + 1'b1;
            wgray_q <= PW'(bin2gray(32'(wbin_q + 1'b1)));
        end
    end

    // Reservation: add granted lengths and release words popped on the far side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_s_q <= '0;
            resv_q   <= '0;
        end else begin
            rbin_s_q <= rbin_s;
            resv_q   <= (sum > (PW+1)'(popped)) ? sum - (PW+1)'(popped) : '0;
        end
    end

    // Outstanding requests: one up per grant, one down per closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_q + OC_W'(req_grant) - OC_W'(close_burst);
        end
    end

    // Sticky error for a beat that arrives while storage is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (wr_en && full) begin
            ovf_q <= 1'b1;
        end
    end

    assign wbin        = wbin_q;
    assign wgray       = wgray_q;
    assign outstanding = out_q;
    assign overflow    = ovf_q;

    p_resv_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resv_q <= (PW+1)'(DEPTH));
    p_out_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_q <= OC_W'(MAX_OUT));
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wbin_q));
    p_wgray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);
    p_grant_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q == OC_W'(MAX_OUT) && !close_burst) |=> out_q == OC_W'(MAX_OUT) || $past(req_grant) == 1'b0);

endmodule

// File: rtl/rrf_rd_ctrl.sv
// Module: core-side control covering the read pointer, the empty flag and pop acceptance.
// Assumes wgray_s is the write pointer already synchronized into this domain.
module rrf_rd_ctrl
    import rrf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty
);
    logic [PW-1:0] rbin_q, rgray_q;
    logic          pop;

    assign empty = (rgray_q == wgray_s);
    assign pop   = rd_en && !empty;

    // Read pointer in binary and Gray form, advanced on each accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (pop) begin
            rbin_q  <= rbin_q + 1'b1;
            rgray_q <= PW'(bin2gray(32'(rbin_q + 1'b1)));
        end
    end

    assign rbin  = rbin_q;
    assign rgray = rgray_q;

    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rbin_q));
    p_rgray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray_q ^ $past(rgray_q)) <= 1);

endmodule

// File: rtl/readret_buffer.sv
// Module: top of the credit-reserving read-return buffer.
// Assumes wclk and rclk are unrelated and that each reset is held for a few edges of its own clock.
module readret_buffer
    import rrf_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int DEPTH     = DEF_DEPTH,
    parameter int MAX_BURST = DEF_MAX_BURST,
    parameter int MAX_OUT   = DEF_MAX_OUT,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1,
    localparam int LEN_W    = $clog2(MAX_BURST + 1),
    localparam int OC_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_grant,
    output logic [OC_W-1:0]   req_outstanding,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    logic [PW-1:0] wbin, wgray, wgray_s, rbin, rgray, rgray_s;
    logic          mem_we;

    rrf_wr_ctrl #(.DEPTH(DEPTH), .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUT)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .req_valid(req_valid), .req_len(req_len),
        .req_grant(req_grant), .outstanding(req_outstanding), .wr_en(wr_en),
        .wr_last(wr_last), .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray),
        .mem_we(mem_we), .full(wr_full), .overflow(wr_overflow)
    );

    rrf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
        .rbin(rbin), .rgray(rgray), .empty(rd_empty)
    );

    rrf_gray_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .gray_out(wgray_s)
    );

    rrf_gray_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .gray_out(rgray_s)
    );

    rrf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(wbin[AW-1:0]), .wdata(wr_data),
        .raddr(rbin[AW-1:0]), .rdata(rd_data)
    );

endmodule

// File: tb/readret_buffer_tb.sv
module readret_buffer_tb;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        wrst_n = 1'b0, rrst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_len = '0;
    logic        req_grant;
    logic [3:0]  req_outstanding;
    logic        wr_en = 1'b0, wr_last = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full, wr_overflow;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_empty;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5   wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    readret_buffer u_dut (
        .wclk(wclk), .wrst_n(wrst_n), .req_valid(req_valid), .req_len(req_len),
        .req_grant(req_grant), .req_outstanding(req_outstanding), .wr_en(wr_en),
        .wr_data(wr_data), .wr_last(wr_last), .wr_full(wr_full),
        .wr_overflow(wr_overflow), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    // Each entry holds {req_len, expected grant}, applied from reset with no data written.
    localparam logic [5:0] VEC [12] = '{
        {5'd0, 1'b0}, {5'd17, 1'b0}, {5'd16, 1'b1}, {5'd1, 1'b1},
        {5'd16, 1'b1}, {5'd16, 1'b1}, {5'd16, 1'b1}, {5'd16, 1'b1},
        {5'd16, 1'b1}, {5'd16, 1'b1}, {5'd1, 1'b0}, {5'd31, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        wrst_n = 1'b0;
        rrst_n = 1'b0;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk) wrst_n = 1'b1;
        @(negedge rclk) rrst_n = 1'b1;
        repeat (2) @(posedge wclk);
    endtask

    task automatic do_req(input int len, input bit exp, input string req);
        @(negedge wclk);
        req_valid = 1'b1;
        req_len   = 5'(len);
        #1;
        check(req_grant == exp, req, 32'(req_grant), 32'(exp));
        @(posedge wclk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wbeat(input logic [31:0] d, input bit last);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        wr_last = last;
        @(posedge wclk);
        #1;
        wr_en   = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic rpop(input logic [31:0] exp, input string req);
        @(negedge rclk);
        check(rd_empty == 1'b0, "R8 not empty before pop", 32'(rd_empty), 32'd0);
        check(rd_data == exp, req, rd_data, exp);
        rd_en = 1'b1;
        @(posedge rclk);
        #1;
        rd_en = 1'b0;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        #1;
        check(rd_empty == 1'b1, "R1 empty", 32'(rd_empty), 32'd1);
        check(wr_full == 1'b0, "R1 full", 32'(wr_full), 32'd0);
        check(wr_overflow == 1'b0, "R1 overflow", 32'(wr_overflow), 32'd0);
        check(req_outstanding == 4'd0, "R1 outstanding", 32'(req_outstanding), 32'd0);

        // Table walk: R2 length limits, R3 slot limit
        foreach (VEC[i]) begin
            do_req(int'(VEC[i][5:1]), VEC[i][0], $sformatf("R2/R3 vector %0d", i));
        end
        check(req_outstanding == 4'd8, "R5 count after table", 32'(req_outstanding), 32'd8);

        // Fresh start for directed tests
        do_reset();
        do_req(128, 1'b0, "R1 ignored");
        for (int i = 0; i < 8; i++) do_req(16, 1'b1, "R1 full space grantable");
        check(req_outstanding == 4'd8, "R5 eight outstanding", 32'(req_outstanding), 32'd8);
        do_req(1, 1'b0, "R3 ninth request refused");
        for (int i = 0; i < 128; i++) wbeat(32'hA000_0000 + 32'(i), (i % 16) == 15);
        check(req_outstanding == 4'd0, "R5 bursts closed", 32'(req_outstanding), 32'd0);
        check(wr_full == 1'b1, "R7 full at 128", 32'(wr_full), 32'd1);
        do_req(1, 1'b0, "R4 no unreserved space");
        repeat (6) @(posedge rclk);
        for (int i = 0; i < 16; i++) rpop(32'hA000_0000 + 32'(i), "R6 order");
        repeat (12) @(posedge wclk);
        #1;
        check(wr_full == 1'b0, "R9 full clears after pops", 32'(wr_full), 32'd0);
        do_req(16, 1'b1, "R9 released space granted, R4 exact fit");
        do_req(1, 1'b0, "R4 one word over");
        for (int i = 128; i < 144; i++) wbeat(32'hA000_0000 + 32'(i), i == 143);
        check(wr_full == 1'b1, "R7 full again", 32'(wr_full), 32'd1);
        wbeat(32'hDEAD_BEEF, 1'b0);
        check(wr_overflow == 1'b1, "R7 overflow set", 32'(wr_overflow), 32'd1);
        check(wr_full == 1'b1, "R7 still full", 32'(wr_full), 32'd1);
        repeat (5) @(posedge wclk);
        #1;
        check(wr_overflow == 1'b1, "R7 overflow sticky", 32'(wr_overflow), 32'd1);
        for (int i = 16; i < 144; i++) rpop(32'hA000_0000 + 32'(i), "R6 R7 order, dropped beat absent");
        @(negedge rclk);
        check(rd_empty == 1'b1, "R8 empty after drain", 32'(rd_empty), 32'd1);

        // R8: a pop while empty must not move the read pointer
        @(negedge rclk) rd_en = 1'b1;
        @(posedge rclk);
        #1 rd_en = 1'b0;
        repeat (12) @(posedge wclk);
        do_req(1, 1'b1, "R9 all space released");
        wbeat(32'h0000_1234, 1'b1);
        repeat (6) @(posedge rclk);
        rpop(32'h0000_1234, "R8 empty pop ignored");
        @(negedge rclk);
        check(rd_empty == 1'b1, "R8 empty after last", 32'(rd_empty), 32'd1);

        do_reset();
        #1;
        check(wr_overflow == 1'b0, "R1 R7 overflow cleared by reset", 32'(wr_overflow), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule